// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synthesizable model of a clocked static memory with a 32-bit data path and a parameterized depth. On every rising clock edge it captures the address, three chip selects, two address strobes, a burst-step control and the write controls. From these it works out whether the cycle deselects the device, starts a burst, steps to the next burst address, or holds the current one. Writes can cover any mix of the four byte lanes. Read data goes through an output register, so it reaches the bus one edge after the edge that captured the read address.

A cycle can be opened by either of two strobes. The host strobe only counts when the primary select is asserted, and it always starts as a read. The access becomes a write only if the write controls are asserted on the next edge while the address is held. The controller strobe is honoured even when the primary select is inactive, but the device then drops out of selection. The two secondary selects are looked at only when a cycle starts. Burst addresses are produced by a separate generator that handles the low two address bits. It follows either a linear order or an interleaved (XOR) order.

A sleep request held for two edges puts the core into a low-activity state. The stored contents are kept in this state. When the request is released, both strobes stay locked out for two more edges. The tri-state data bus is modelled as separate data-in, data-out and drive-enable signals. The drive enable follows the asynchronous output-enable input.

Top module: `burst_sram`

## Requirements
- R1: After a synchronous reset, `d_oe` and `sleep_ack` are both 0.
- R2: When `host_strobe_n` is sampled low with `cs_a_n` low and no lockout, the core starts a read, whatever the write controls say. With `out_en_n` low, the data from that address is on `d_out` with `d_oe` high after the next rising edge.
- R3: When `cs_a_n` is high, `host_strobe_n` is ignored. When `ctl_strobe_n` is sampled low with `cs_a_n` high, the core is deselected: `d_oe` stays 0 and no write takes place.
- R4: A start with `cs_b` low or `cs_c_n` high deselects the core, and no data is driven. In a cycle with no strobe, `cs_b` and `cs_c_n` have no effect.
- R5: A host-strobe start followed, on the next edge, by asserted write controls with `step_n` high writes the data of that edge to the started address.
- R6: A controller-strobe start with the selects valid and the write controls asserted writes `d_in` of that same edge.
- R7: With `wr_all_n` low, all four lanes are written. Otherwise, with `lane_wr_n` low, each low bit i of `lane_sel_n` writes bits 8i+7..8i. If neither holds, the cycle is a read and memory is unchanged.
- R8: In a selected cycle with both strobes high and `step_n` low, the burst moves to the next address. The upper address bits stay fixed. After n steps the low two bits are (base + n) mod 4 when `seq_linear` is 1, and base XOR n when it is 0.
- R9: In a selected cycle with both strobes high and `step_n` high, the current address is accessed again.
- R10: `d_oe` is 1 only while `out_en_n` is low and the output register holds read data. `out_en_n` takes effect without a clock edge.
- R11: With `sleep_req` sampled high on two edges in a row, `sleep_ack` becomes 1. While asleep, `d_oe` is 0, strobes are ignored, and memory contents are kept.
- R12: After `sleep_req` is sampled low while asleep, both strobes are ignored on the next two edges and honoured on the third.
- R13: A read started on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, captured at a start |
| cs_a_n | input | 1 | Primary chip select, active low; gates the host strobe |
| cs_b | input | 1 | Secondary chip select, active high, sampled at a start |
| cs_c_n | input | 1 | Secondary chip select, active low, sampled at a start |
| host_strobe_n | input | 1 | Host address strobe, active low, always starts a read |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low; high holds the current address |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit i = byte i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved; held static |
| d_in | input | 32 | Write data |
| d_out | output | 32 | Read data from the output register |
| d_oe | output | 1 | Bus drive enable |
| sleep_ack | output | 1 | High while in the sleep state |

## Verification
The assertions check, on every cycle, how the strobes are decoded. A host-strobe start with valid selects always produces a read access. A host strobe with the primary select inactive produces no access. A start with invalid secondary selects produces no access. A hold cycle keeps its address. Sleep and the wake lockout block all accesses. Every valid output comes from a read access on the previous edge. Only the bench scenarios can show the data behaviour that depends on memory contents: lane-masked merges, the two burst orders, the write decided one edge after a host strobe, retention across sleep, and read-after-write.

// File: rtl/sram_pkg.sv
// Shared types for the burst SRAM core.
// Assumes: nothing beyond the standard language.
package sram_pkg;

    // Kind of cycle decoded from the strobes, the burst step and the select state
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_START = 2'd1,
        CYC_NEXT  = 2'd2,
        CYC_HOLD  = 2'd3
    } cyc_e;

endpackage

// File: rtl/sram_burst_gen.sv
// Burst address generator: produces the low address bits of the current beat
// from the captured base bits and the beat count.
// Assumes: seq_linear is held static during operation.
module sram_burst_gen #(
    parameter int BURST_W = 2
) (
    input  logic               linear,
    input  logic [BURST_W-1:0] base_lo,
    input  logic [BURST_W-1:0] step,
    output logic [BURST_W-1:0] addr_lo
);

    // Linear order wraps an adder; interleaved order flips bits with XOR
    always_comb begin
        if (linear)
            addr_lo = base_lo + step;
        else
            addr_lo = base_lo ^ step;
    end

endmodule

// File: rtl/sram_ctrl.sv
// Cycle decoder and access stage. It samples the selects, the strobes and the
// burst step, tracks burst and sleep state, and registers one access
// (address, lanes, data, read/write) for the array.
// Assumes: synchronous active-low reset; all controls are sampled on the rising edge.
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int AW          = 10,
    parameter int DW          = 32,
    parameter int BURST_W     = 2,
    parameter int SLEEP_ENTRY = 2,
    parameter int WAKE_LOCK   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            cs_a_n,
    input  logic            cs_b,
    input  logic            cs_c_n,
    input  logic            host_strobe_n,
    input  logic            ctl_strobe_n,
    input  logic            step_n,
    input  logic            wr_all_n,
    input  logic            lane_wr_n,
    input  logic [DW/8-1:0] lane_sel_n,
    input  logic            sleep_req,
    input  logic            seq_linear,
    input  logic [DW-1:0]   d_in,
    output logic            s1_valid,
    output logic            s1_wr,
    output logic [DW/8-1:0] s1_be,
    output logic [AW-1:0]   s1_addr,
    output logic [DW-1:0]   s1_data,
    output logic            asleep
);

    localparam int NB  = DW / 8;
    localparam int SHW = $clog2(SLEEP_ENTRY + 1);
    localparam int LKW = $clog2(WAKE_LOCK + 1);

    logic [AW-1:0]      base_q, base_nxt, eff_addr;
    logic [BURST_W-1:0] step_q, step_nxt, lo_bits;
    logic               sel_q, sel_nxt;
    logic [SHW-1:0]     zz_hold_q;
    logic [LKW-1:0]     lock_q;
    logic               blocked, go_host, go_ctl, start_ok, acc, acc_wr;
    logic [NB-1:0]      lanes;
    cyc_e               kind;

    assign asleep   = (zz_hold_q == SHW'(SLEEP_ENTRY));
    assign blocked  = asleep || (lock_q != '0);
    assign go_host  = !blocked && !host_strobe_n && !cs_a_n;
    assign go_ctl   = !blocked && !ctl_strobe_n && !go_host;
    assign start_ok = cs_b && !cs_c_n && !cs_a_n;

    // Lane write mask from the global and per-lane write controls
    always_comb begin
        if (!wr_all_n)
            lanes = '1;
        else if (!lane_wr_n)
            lanes = ~lane_sel_n;
        else
            lanes = '0;
    end

    // Cycle classification
    always_comb begin
        kind = CYC_IDLE;
        if (go_host || go_ctl)
            kind = CYC_START;
        else if (sel_q && !blocked)
            kind = step_n ? CYC_HOLD : CYC_NEXT;
    end

    // Next burst base and beat count
    always_comb begin
        base_nxt = base_q;
        step_nxt = step_q;
        case (kind)
            CYC_START: begin
                base_nxt = addr;
                step_nxt = '0;
            end
            CYC_NEXT: step_nxt = step_q + 1'b1;
            default: ;
        endcase
    end

    // Next selected state: set by a start, cleared while blocked
    always_comb begin
        sel_nxt = sel_q;
        if (kind == CYC_START)
            sel_nxt = start_ok;
        else if (blocked)
            sel_nxt = 1'b0;
    end

    sram_burst_gen #(
        .BURST_W (BURST_W)
    ) u_burst_gen (
        .linear  (seq_linear),
        .base_lo (base_nxt[BURST_W-1:0]),
        .step    (step_nxt),
        .addr_lo (lo_bits)
    );

    assign eff_addr = {base_nxt[AW-1:BURST_W], lo_bits};
    assign acc      = ((kind == CYC_START) && start_ok) || (kind == CYC_NEXT) || (kind == CYC_HOLD);
    assign acc_wr   = (|lanes) && !go_host;

    // Burst state and access stage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            base_q   <= '0;
            step_q   <= '0;
            s1_valid <= 1'b0;
            s1_wr    <= 1'b0;
            s1_be    <= '0;
            s1_addr  <= '0;
            s1_data  <= '0;
        end else begin
            sel_q    <= sel_nxt;
            base_q   <= base_nxt;
            step_q   <= step_nxt;
            s1_valid <= acc;
            s1_wr    <= acc && acc_wr;
            s1_be    <= lanes;
            s1_addr  <= eff_addr;
            s1_data  <= d_in;
        end
    end

    // Sleep entry counter and wake lockout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zz_hold_q <= '0;
            lock_q    <= '0;
        end else begin
            if (!sleep_req)
                zz_hold_q <= '0;
            else if (!asleep)
                zz_hold_q <= zz_hold_q + 1'b1;
            if (asleep && !sleep_req)
                lock_q <= LKW'(WAKE_LOCK);
            else if (lock_q != '0)
                lock_q <= lock_q - 1'b1;
        end
    end

    // R2: a host-strobe start with valid selects gives a read access
    p_host_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && !host_strobe_n && !cs_a_n && cs_b && !cs_c_n) |=> (s1_valid && !s1_wr));

    // R3: the host strobe alone with the primary select inactive opens nothing
    p_host_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && !host_strobe_n && cs_a_n && ctl_strobe_n && !sel_q) |=> !s1_valid);

    // R4: a start with an invalid secondary select makes no access
    p_start_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && (!ctl_strobe_n || (!host_strobe_n && !cs_a_n)) && (!cs_b || cs_c_n)) |=> !s1_valid);

    // R9: a hold cycle repeats the address of the previous access
    p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && host_strobe_n && ctl_strobe_n && step_n && sel_q && s1_valid)
        |=> (s1_valid && (s1_addr == $past(s1_addr))));

    // R11: no access is made while asleep
    p_sleep_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> !s1_valid);

    // R12: no access is made during the wake lockout
    p_wake_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != '0) |=> !s1_valid);

endmodule

// File: rtl/sram_array.sv
// Storage array with byte-lane writes and a registered read port feeding the
// output register.
// Assumes: one access per cycle from the access stage; contents are not reset.
module sram_array #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s1_valid,
    input  logic            s1_wr,
    input  logic [DW/8-1:0] s1_be,
    input  logic [AW-1:0]   s1_addr,
    input  logic [DW-1:0]   s1_data,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid
);

    localparam int NB    = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Lane-masked write of the registered access
    always_ff @(posedge clk) begin
        if (s1_valid && s1_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (s1_be[b])
                    mem[s1_addr][8*b +: 8] <= s1_data[8*b +: 8];
            end
        end
    end

    // Output register loaded by a read access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= s1_valid && !s1_wr;
            if (s1_valid && !s1_wr)
                rd_data <= mem[s1_addr];
        end
    end

    // R2: valid output data always comes from a read access one edge earlier
    p_out_from_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(s1_valid && !s1_wr));

endmodule

// File: rtl/burst_sram.sv
// Top of the pipelined burst SRAM core: cycle decoder, storage array and the
// bus drive gate.
// Assumes: the bus is split into d_in, d_out and d_oe; out_en_n is asynchronous.
module burst_sram #(
    parameter int AW          = 10,
    parameter int DW          = 32,
    parameter int BURST_W     = 2,
    parameter int SLEEP_ENTRY = 2,
    parameter int WAKE_LOCK   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            cs_a_n,
    input  logic            cs_b,
    input  logic            cs_c_n,
    input  logic            host_strobe_n,
    input  logic            ctl_strobe_n,
    input  logic            step_n,
    input  logic            wr_all_n,
    input  logic            lane_wr_n,
    input  logic [DW/8-1:0] lane_sel_n,
    input  logic            out_en_n,
    input  logic            sleep_req,
    input  logic            seq_linear,
    input  logic [DW-1:0]   d_in,
    output logic [DW-1:0]   d_out,
    output logic            d_oe,
    output logic            sleep_ack
);

    localparam int NB = DW / 8;

    logic          s1_valid, s1_wr, rd_valid, asleep;
    logic [NB-1:0] s1_be;
    logic [AW-1:0] s1_addr;
    logic [DW-1:0] s1_data, rd_data;

    sram_ctrl #(
        .AW          (AW),
        .DW          (DW),
        .BURST_W     (BURST_W),
        .SLEEP_ENTRY (SLEEP_ENTRY),
        .WAKE_LOCK   (WAKE_LOCK)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .cs_a_n        (cs_a_n),
        .cs_b          (cs_b),
        .cs_c_n        (cs_c_n),
        .host_strobe_n (host_strobe_n),
        .ctl_strobe_n  (ctl_strobe_n),
        .step_n        (step_n),
        .wr_all_n      (wr_all_n),
        .lane_wr_n     (lane_wr_n),
        .lane_sel_n    (lane_sel_n),
        .sleep_req     (sleep_req),
        .seq_linear    (seq_linear),
        .d_in          (d_in),
        .s1_valid      (s1_valid),
        .s1_wr         (s1_wr),
        .s1_be         (s1_be),
        .s1_addr       (s1_addr),
        .s1_data       (s1_data),
        .asleep        (asleep)
    );

    sram_array #(
        .AW (AW),
        .DW (DW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_wr    (s1_wr),
        .s1_be    (s1_be),
        .s1_addr  (s1_addr),
        .s1_data  (s1_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Bus gate: drive only valid read data, when enabled and awake
    assign d_out     = rd_data;
    assign d_oe      = rd_valid && !out_en_n && !asleep;
    assign sleep_ack = asleep;

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cs_a_n, cs_b, cs_c_n, host_strobe_n, ctl_strobe_n, step_n;
    logic          wr_all_n, lane_wr_n, out_en_n, sleep_req, seq_linear;
    logic [3:0]    lane_sel_n;
    logic [31:0]   d_in, d_out;
    logic          d_oe, sleep_ack;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] mdl [1 << AW];

    always #2 clk = ~clk;

    burst_sram #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .host_strobe_n(host_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n),
        .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep_req(sleep_req),
        .seq_linear(seq_linear), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .sleep_ack(sleep_ack)
    );

    // Lanes written, per R7
    function automatic logic [3:0] lane_mask(input logic wa, input logic lw, input logic [3:0] ls);
        if (!wa) return 4'hF;
        if (!lw) return ~ls;
        return 4'h0;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (m[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // Burst address after n steps, per R8
    function automatic logic [AW-1:0] beat(input logic [AW-1:0] base, input int n, input logic lin);
        logic [1:0] s = 2'(n);
        logic [1:0] lo = lin ? 2'(base[1:0] + s) : (base[1:0] ^ s);
        return {base[AW-1:2], lo};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        host_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
        wr_all_n = 1; lane_wr_n = 1; lane_sel_n = 4'hF;
        cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    endtask

    task automatic desel();
        idle_in(); ctl_strobe_n = 0; cs_b = 0;
        tick();
        idle_in();
    endtask

    task automatic wr_c(input logic [AW-1:0] a, input logic [31:0] d,
                        input logic wa, input logic lw, input logic [3:0] ls);
        idle_in(); ctl_strobe_n = 0; addr = a; d_in = d;
        wr_all_n = wa; lane_wr_n = lw; lane_sel_n = ls;
        tick();
        mdl[a] = merge(mdl[a], d, lane_mask(wa, lw, ls));
        desel();
    endtask

    task automatic rd_p(input logic [AW-1:0] a, input string req);
        idle_in(); host_strobe_n = 0; addr = a; out_en_n = 0;
        tick();
        desel();
        check(req, 32'(d_oe), 32'd1);
        check(req, d_out, mdl[a]);
    endtask

    task automatic burst_rd(input logic [AW-1:0] base, input logic lin, input string req);
        seq_linear = lin;
        idle_in(); host_strobe_n = 0; addr = base; out_en_n = 0;
        tick();
        idle_in(); step_n = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(req, d_out, mdl[beat(base, i, lin)]);
        end
        desel();
        check(req, d_out, mdl[beat(base, 3, lin)]);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 0; idle_in(); addr = '0; d_in = '0; out_en_n = 0;
        sleep_req = 0; seq_linear = 1;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: reset state
        check("R1", 32'(d_oe), 32'd0);
        check("R1", 32'(sleep_ack), 32'd0);

        // R6 and R2: controller-strobe write, host-strobe read
        wr_c(10'h010, 32'hA5A5_1234, 0, 1, 4'hF);
        rd_p(10'h010, "R6");
        rd_p(10'h010, "R2");

        // R7: per-lane write, then a cycle with no lane selected stays a read
        wr_c(10'h010, 32'h0000_BB00, 1, 0, 4'b1101);
        rd_p(10'h010, "R7");
        wr_c(10'h010, 32'hFFFF_FFFF, 1, 1, 4'h0);
        rd_p(10'h010, "R7");

        // R5: host-strobe start, write decided on the following edge
        idle_in(); host_strobe_n = 0; addr = 10'h020; out_en_n = 1;
        wr_all_n = 0; d_in = 32'hDEAD_0001; // ignored on the start edge
        tick();
        idle_in(); wr_all_n = 0; d_in = 32'h1357_9BDF;
        tick();
        mdl[10'h020] = 32'h1357_9BDF;
        desel();
        rd_p(10'h020, "R5");

        // R13: read on the edge right after a write to the same address
        idle_in(); ctl_strobe_n = 0; addr = 10'h030; wr_all_n = 0; d_in = 32'h0BAD_F00D;
        tick();
        mdl[10'h030] = 32'h0BAD_F00D;
        idle_in(); host_strobe_n = 0; addr = 10'h030; out_en_n = 0;
        tick();
        desel();
        check("R13", d_out, 32'h0BAD_F00D);

        // Burst data for R8 and R9
        for (int i = 0; i < 4; i++) wr_c(10'h040 + 10'(i), 32'h4000_0000 + 32'(i), 0, 1, 4'hF);
        burst_rd(10'h041, 1'b1, "R8 linear");
        burst_rd(10'h041, 1'b0, "R8 interleaved");
        burst_rd(10'h042, 1'b0, "R8 interleaved");
        seq_linear = 1;

        // R9: hold repeats the address, then a step moves on
        idle_in(); host_strobe_n = 0; addr = 10'h040; out_en_n = 0;
        tick();
        idle_in();
        tick();
        check("R9", d_out, mdl[10'h040]);
        step_n = 0;
        tick();
        check("R9", d_out, mdl[10'h040]);
        desel();
        check("R9", d_out, mdl[10'h041]);

        // R10: output enable acts without a clock edge
        idle_in(); host_strobe_n = 0; addr = 10'h042; out_en_n = 1;
        tick();
        idle_in();
        tick();
        check("R10", 32'(d_oe), 32'd0);
        out_en_n = 0;
        #0.5;
        check("R10", 32'(d_oe), 32'd1);
        check("R10", d_out, mdl[10'h042]);
        desel();
        tick();
        check("R10", 32'(d_oe), 32'd0);

        // R4: invalid secondary select at the start deselects
        idle_in(); host_strobe_n = 0; addr = 10'h040; cs_c_n = 1;
        tick();
        idle_in(); step_n = 0;
        tick();
        tick();
        check("R4", 32'(d_oe), 32'd0);
        // R4: secondary selects ignored in a stepping cycle
        idle_in(); host_strobe_n = 0; addr = 10'h040;
        tick();
        idle_in(); step_n = 0; cs_b = 0; cs_c_n = 1;
        tick();
        check("R4", d_out, mdl[10'h040]);
        desel();
        check("R4", d_out, mdl[10'h041]);
        tick();

        // R3: host strobe with the primary select high is ignored
        idle_in(); host_strobe_n = 0; cs_a_n = 1; addr = 10'h040;
        tick();
        idle_in();
        tick();
        check("R3", 32'(d_oe), 32'd0);
        // R3: controller strobe with the primary select high deselects; no write
        idle_in(); ctl_strobe_n = 0; cs_a_n = 1; addr = 10'h040; wr_all_n = 0; d_in = 32'hBAD0_BAD0;
        tick();
        idle_in();
        tick();
        check("R3", 32'(d_oe), 32'd0);
        rd_p(10'h040, "R3");

        // R11: sleep entry, retention, strobes ignored
        sleep_req = 1;
        tick();
        check("R11", 32'(sleep_ack), 32'd0);
        tick();
        check("R11", 32'(sleep_ack), 32'd1);
        idle_in(); ctl_strobe_n = 0; addr = 10'h010; wr_all_n = 0; d_in = 32'h5EE9_5EE9;
        tick();
        idle_in(); host_strobe_n = 0; addr = 10'h010;
        tick();
        tick();
        check("R11", 32'(d_oe), 32'd0);
        // R12: wake lockout
        sleep_req = 0;
        idle_in();
        tick();
        check("R12", 32'(sleep_ack), 32'd0);
        host_strobe_n = 0; addr = 10'h010; out_en_n = 0;
        tick();
        tick();
        check("R12", 32'(d_oe), 32'd0);
        tick();
        check("R12", 32'(d_oe), 32'd0);
        desel();
        check("R12", 32'(d_oe), 32'd1);
        check("R11", d_out, mdl[10'h010]);

        // Random full write, lane-masked overwrite and read back (R7, R6, R2)
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] a  = AW'($urandom);
            logic [3:0]    ls = 4'($urandom);
            logic          lw = 1'($urandom);
            wr_c(a, $urandom, 0, 1, 4'hF);
            wr_c(a, $urandom, 1, lw, ls);
            rd_p(a, "R7");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule